// File: doc/BRIEF.md
# Serial In-System Flash Configuration Port

This block is a four-wire test access port used only to configure on-chip flash after the part is mounted on a board. It has no boundary-scan cells. The port has a sixteen-state controller clocked by `tck` and an 8-bit instruction register. Depending on the instruction, it selects a 1-bit bypass stage, a 3-bit option stage or a 24-bit address/data stage. Program, sector-erase, chip-erase and read requests go to a flash-operation interface as one-cycle start pulses. The flash side answers with busy and error levels.

The serial output is not driven until the enable instruction is loaded. The enable instruction's own data stage then turns on two side-band pins. The first is a status pin that follows the flash ready/busy level. The second is an active-low error flag that latches. Either pin can be set as push-pull or open-drain. A security lock is loaded at power-on. While it is set, only chip erase is accepted, and a chip erase that completes cleanly clears the lock. Each sector has its own protect bit, and an erase aimed at a protected sector is refused and flagged as an error.

Top module: `isc_tap_ctrl`

## Requirements
- R1: After power-on reset, `tdo_oe`, `stat_oe` and `err_oe` are low. Loading the enable instruction (opcode 8'h10) raises `tdo_oe`. Loading the disable instruction (8'h11) lowers all three and clears the pin options.
- R2: The controller enters its reset state after five rising `tck` edges with `tms` high, and that state selects bypass. Any opcode outside the table in R3 also selects bypass. Bypass is one stage that captures 0, so the output stream is the input stream delayed by one bit.
- R3: The instruction register is 8 bits wide, shifted LSB first, and captures 8'h01. The opcodes are: enable 8'h10, disable 8'h11, clear 8'h12, program 8'h20, sector erase 8'h21, chip erase 8'h22, read 8'h23, bypass 8'hFF.
- R4: Under enable, a 3-bit option stage is written at Update-DR. Bit0 turns the side-band pins on, bit1 makes the status pin open-drain, and bit2 makes the error pin open-drain.
- R5: The status level is high when `fl_busy` is low and low when it is high. In push-pull mode the pin drives that level. In open-drain mode the pin drives low only when the level is low and is otherwise released.
- R6: The error level is active low. It goes low on any rising `tck` edge where `fl_err` is high, stays low, and returns high on Update-IR of the clear instruction. Open-drain mode behaves as in R5.
- R7: A chip reset (`chip_rst_n` low at a rising edge) clears the error only if a disable instruction has been loaded since the last enable. Otherwise it has no effect on the error.
- R8: A flash instruction scans a 24-bit stage LSB first, holding {address[15:0], data[7:0]}. Update-DR then drives `fl_start` for one `tck` cycle with `fl_cmd` set to 0 for program, 1 for sector erase, 2 for chip erase or 3 for read. Requests are issued only after enable.
- R9: A request whose Update-DR sees `fl_busy` high is dropped and not issued later.
- R10: The sector is address bits [15:12]. A sector erase aimed at a sector whose `prot_mask` bit is set is not issued and sets the error.
- R11: While the lock is set, program, sector erase and read are ignored with no error. The data half of a captured stage reads as 0.
- R12: A chip erase completes when `fl_busy` falls after it was issued. If `fl_err` is low in that cycle, the lock is cleared; if it is high, the lock remains.
- R13: Capture-DR of a flash instruction loads {last issued address, `fl_rdata`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tck | input | 1 | Serial clock |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out value, changes on falling `tck` |
| tdo_oe | output | 1 | Drive enable for `tdo` |
| chip_rst_n | input | 1 | Chip reset pulse, active low, sampled on `tck` |
| sec_init | input | 1 | Security lock value loaded at power-on |
| prot_mask | input | 16 | Per-sector erase protect bits |
| stat_o | output | 1 | Status pin value |
| stat_oe | output | 1 | Status pin drive enable |
| err_o | output | 1 | Error pin value |
| err_oe | output | 1 | Error pin drive enable |
| fl_start | output | 1 | One-cycle flash request |
| fl_cmd | output | 2 | Request kind |
| fl_addr | output | 16 | Request address |
| fl_wdata | output | 8 | Program data |
| fl_rdata | input | 8 | Flash read data |
| fl_busy | input | 1 | Flash operation in progress |
| fl_err | input | 1 | Flash operation error |

## Verification
The hardest state to reach is the lock being cleared. It needs a power-on with the lock loaded, the enable and option scans, refused program, erase and read scans, and a chip erase. The bench then drives `fl_busy` from high to low with and without `fl_err`, and observes the lock only through the data half of later read captures. A second hard case is the conditional chip-reset clear of the error. The bench reaches it by alternating disable and enable scans with reset pulses, and reads the flag back on the error pin after re-enabling. The pin modes are swept over all eight option values, both error states and both busy levels.

// File: rtl/isc_tap_ctrl.sv
module isc_tap_ctrl #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int SB = 4
) (
  input  logic              por_n,
  input  logic              tck,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdo_oe,
  input  logic              chip_rst_n,
  input  logic              sec_init,
  input  logic [(1<<SB)-1:0] prot_mask,
  output logic              stat_o,
  output logic              stat_oe,
  output logic              err_o,
  output logic              err_oe,
  output logic              fl_start,
  output logic [1:0]        fl_cmd,
  output logic [AW-1:0]     fl_addr,
  output logic [DW-1:0]     fl_wdata,
  input  logic [DW-1:0]     fl_rdata,
  input  logic              fl_busy,
  input  logic              fl_err
);
  localparam int DRW = AW + DW;
  localparam logic [7:0] OP_ENABLE  = 8'h10;
  localparam logic [7:0] OP_DISABLE = 8'h11;
  localparam logic [7:0] OP_CLEAR   = 8'h12;
  localparam logic [7:0] OP_PROG    = 8'h20;
  localparam logic [7:0] OP_ERASE   = 8'h21;
  localparam logic [7:0] OP_CHIP    = 8'h22;
  localparam logic [7:0] OP_READ    = 8'h23;
  localparam logic [7:0] OP_BYPASS  = 8'hFF;

  typedef enum logic [3:0] {
    S_RESET, S_IDLE, S_DSEL, S_DCAP, S_DSH, S_DEX1, S_DPAU, S_DEX2, S_DUPD,
    S_ISEL, S_ICAP, S_ISH, S_IEX1, S_IPAU, S_IEX2, S_IUPD
  } tap_t;

  tap_t st, nx;
  logic [7:0]     ir_q, ir_sh;
  logic           byp;
  logic [2:0]     opt_sh, opt_q;
  logic [DRW-1:0] fdr;
  logic           isc_on, dis_seen, err_q, sec_q, chip_pend, busy_q, tdo_q;
  logic [1:0]     fcmd;

  always_comb begin
    case (st)
      S_RESET: nx = tms ? S_RESET : S_IDLE;
      S_IDLE:  nx = tms ? S_DSEL  : S_IDLE;
      S_DSEL:  nx = tms ? S_ISEL  : S_DCAP;
      S_DCAP:  nx = tms ? S_DEX1  : S_DSH;
      S_DSH:   nx = tms ? S_DEX1  : S_DSH;
      S_DEX1:  nx = tms ? S_DUPD  : S_DPAU;
      S_DPAU:  nx = tms ? S_DEX2  : S_DPAU;
      S_DEX2:  nx = tms ? S_DUPD  : S_DSH;
      S_DUPD:  nx = tms ? S_DSEL  : S_IDLE;
      S_ISEL:  nx = tms ? S_RESET : S_ICAP;
      S_ICAP:  nx = tms ? S_IEX1  : S_ISH;
      S_ISH:   nx = tms ? S_IEX1  : S_ISH;
      S_IEX1:  nx = tms ? S_IUPD  : S_IPAU;
      S_IPAU:  nx = tms ? S_IEX2  : S_IPAU;
      S_IEX2:  nx = tms ? S_IUPD  : S_ISH;
      S_IUPD:  nx = tms ? S_DSEL  : S_IDLE;
    endcase
  end

  always_comb begin
    case (ir_q)
      OP_ERASE: fcmd = 2'd1;
      OP_CHIP:  fcmd = 2'd2;
      OP_READ:  fcmd = 2'd3;
      default:  fcmd = 2'd0;
    endcase
  end

  wire is_opt   = (ir_q == OP_ENABLE);
  wire is_flash = (ir_q == OP_PROG) || (ir_q == OP_ERASE) || (ir_q == OP_CHIP) || (ir_q == OP_READ);
  wire [SB-1:0] sect = fdr[DRW-1 -: SB];
  wire go_ok    = (st == S_DUPD) && is_flash && isc_on && !fl_busy;
  wire blocked  = sec_q && (ir_q != OP_CHIP);
  wire refused  = (ir_q == OP_ERASE) && prot_mask[sect];
  wire issue    = go_ok && !blocked && !refused;
  wire bad_ers  = go_ok && !blocked && refused;
  wire chip_done = busy_q && !fl_busy && chip_pend;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      st     <= S_RESET;
      ir_q   <= OP_BYPASS;
      ir_sh  <= '0;
      byp    <= 1'b0;
      opt_sh <= '0;
      fdr    <= '0;
    end else begin
      st <= nx;
      case (st)
        S_RESET: ir_q  <= OP_BYPASS;
        S_ICAP:  ir_sh <= 8'h01;
        S_ISH:   ir_sh <= {tdi, ir_sh[7:1]};
        S_IUPD:  ir_q  <= ir_sh;
        S_DCAP: begin
          byp    <= 1'b0;
          opt_sh <= opt_q;
          fdr    <= {fl_addr, sec_q ? {DW{1'b0}} : fl_rdata};
        end
        S_DSH: begin
          byp    <= tdi;
          opt_sh <= {tdi, opt_sh[2:1]};
          fdr    <= {tdi, fdr[DRW-1:1]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) begin
      isc_on    <= 1'b0;
      dis_seen  <= 1'b0;
      opt_q     <= '0;
      err_q     <= 1'b0;
      sec_q     <= sec_init;
      chip_pend <= 1'b0;
      busy_q    <= 1'b0;
      fl_start  <= 1'b0;
      fl_cmd    <= '0;
      fl_addr   <= '0;
      fl_wdata  <= '0;
    end else begin
      fl_start <= issue;
      busy_q   <= fl_busy;
      if (chip_done) begin
        chip_pend <= 1'b0;
        if (!fl_err) sec_q <= 1'b0;
      end
      if (issue) begin
        fl_cmd   <= fcmd;
        fl_addr  <= fdr[DRW-1:DW];
        fl_wdata <= fdr[DW-1:0];
        if (ir_q == OP_CHIP) chip_pend <= 1'b1;
      end
      if (st == S_DUPD && is_opt) opt_q <= opt_sh;
      if (st == S_IUPD) begin
        case (ir_sh)
          OP_ENABLE:  begin isc_on <= 1'b1; dis_seen <= 1'b0; end
          OP_DISABLE: begin isc_on <= 1'b0; dis_seen <= 1'b1; opt_q <= '0; end
          OP_CLEAR:   err_q <= 1'b0;
          default: ;
        endcase
      end
      if (!chip_rst_n && dis_seen) err_q <= 1'b0;
      if (fl_err || bad_ers) err_q <= 1'b1;
    end
  end

  wire dr_lsb = is_opt ? opt_sh[0] : (is_flash ? fdr[0] : byp);

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n)           tdo_q <= 1'b0;
    else if (st == S_ISH) tdo_q <= ir_sh[0];
    else if (st == S_DSH) tdo_q <= dr_lsb;
  end

  wire ext      = isc_on & opt_q[0];
  wire stat_lvl = ~fl_busy;
  wire err_lvl  = ~err_q;

  assign tdo     = tdo_q;
  assign tdo_oe  = isc_on;
  assign stat_o  = ext & ~opt_q[1] & stat_lvl;
  assign stat_oe = ext & (~opt_q[1] | ~stat_lvl);
  assign err_o   = ext & ~opt_q[2] & err_lvl;
  assign err_oe  = ext & (~opt_q[2] | ~err_lvl);
endmodule

module isc_tap_ctrl_chk #(
  parameter int AW = 16,
  parameter int SB = 4
) (
  input logic              tck,
  input logic              por_n,
  input logic              chip_rst_n,
  input logic              fl_start,
  input logic [1:0]        fl_cmd,
  input logic [AW-1:0]     fl_addr,
  input logic              fl_busy,
  input logic [(1<<SB)-1:0] prot_mask,
  input logic              sec_q,
  input logic              err_q,
  input logic [7:0]        ir_q
);
  // R9
  no_start_busy_chk: assert property (@(posedge tck) disable iff (!por_n)
    fl_start |-> !$past(fl_busy));
  // R8
  start_pulse_chk: assert property (@(posedge tck) disable iff (!por_n)
    fl_start |=> !fl_start);
  // R10
  no_prot_erase_chk: assert property (@(posedge tck) disable iff (!por_n)
    (fl_start && fl_cmd == 2'd1) |-> !prot_mask[fl_addr[AW-1 -: SB]]);
  // R11
  lock_only_chip_chk: assert property (@(posedge tck) disable iff (!por_n)
    (fl_start && sec_q) |-> (fl_cmd == 2'd2));
  // R12
  lock_no_rise_chk: assert property (@(posedge tck) disable iff (!por_n)
    sec_q |-> $past(sec_q));
  // R6
  err_clear_cause_chk: assert property (@(posedge tck) disable iff (!por_n)
    $fell(err_q) |-> (!$past(chip_rst_n) || ir_q == 8'h12));
endmodule

bind isc_tap_ctrl isc_tap_ctrl_chk #(.AW(AW), .SB(SB)) u_chk (
  .tck(tck), .por_n(por_n), .chip_rst_n(chip_rst_n), .fl_start(fl_start),
  .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_busy(fl_busy), .prot_mask(prot_mask),
  .sec_q(sec_q), .err_q(err_q), .ir_q(ir_q)
);

// File: tb/isc_tap_ctrl_test.sv
module isc_tap_ctrl_test;
  localparam int TCK_PERIOD = 20;

  logic tck = 0, tms = 1, tdi = 0, por_n = 0, chip_rst_n = 1, sec_init = 0;
  logic fl_busy = 0, fl_err = 0;
  logic [15:0] prot_mask = 16'hA5C3;
  logic tdo, tdo_oe, stat_o, stat_oe, err_o, err_oe, fl_start;
  logic [1:0] fl_cmd;
  logic [15:0] fl_addr;
  logic [7:0] fl_wdata, fl_rdata;
  int n_chk = 0, n_fail = 0, n_start = 0;
  logic [1:0] l_cmd = 0;
  logic [15:0] l_addr = 0;
  logic [7:0] l_data = 0;

  isc_tap_ctrl uut (
    .por_n(por_n), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .chip_rst_n(chip_rst_n), .sec_init(sec_init), .prot_mask(prot_mask),
    .stat_o(stat_o), .stat_oe(stat_oe), .err_o(err_o), .err_oe(err_oe),
    .fl_start(fl_start), .fl_cmd(fl_cmd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_busy(fl_busy), .fl_err(fl_err)
  );

  always #(TCK_PERIOD/2) tck = ~tck;
  assign fl_rdata = fl_addr[7:0] ^ fl_addr[15:8] ^ 8'h3C;

  always @(negedge tck) if (fl_start === 1'b1) begin
    n_start++;
    l_cmd = fl_cmd; l_addr = fl_addr; l_data = fl_wdata;
  end

  function automatic logic [7:0] rd(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic clk1(input logic m, input logic d, output logic o);
    @(negedge tck); #2;
    tms = m; tdi = d; o = tdo;
    @(posedge tck); #1;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) clk1(0, 0, o);
  endtask

  task automatic to_reset();
    logic o;
    for (int i = 0; i < 5; i++) clk1(1, 0, o);
    clk1(0, 0, o);
  endtask

  task automatic scan_ir(input logic [7:0] v, output logic [7:0] cap);
    logic o;
    cap = '0;
    clk1(1, 0, o); clk1(1, 0, o); clk1(0, 0, o); clk1(0, 0, o);
    for (int i = 0; i < 8; i++) begin clk1(i == 7, v[i], o); cap[i] = o; end
    clk1(1, 0, o); clk1(0, 0, o); idle(1);
  endtask

  task automatic ir(input logic [7:0] v);
    logic [7:0] c;
    scan_ir(v, c);
  endtask

  task automatic scan_dr(input int n, input logic [23:0] v, output logic [23:0] cap);
    logic o;
    cap = '0;
    clk1(1, 0, o); clk1(0, 0, o); clk1(0, 0, o);
    for (int i = 0; i < n; i++) begin clk1(i == n-1, v[i], o); cap[i] = o; end
    clk1(1, 0, o); clk1(0, 0, o); idle(2);
  endtask

  task automatic dr(input int n, input logic [23:0] v);
    logic [23:0] c;
    scan_dr(n, v, c);
  endtask

  task automatic chip_reset_pulse();
    chip_rst_n = 0; idle(1); chip_rst_n = 1; idle(1);
  endtask

  initial begin
    logic [7:0] c8;
    logic [23:0] c24;
    int s0;
    logic [15:0] a;
    logic [7:0] d;

    #(TCK_PERIOD*3 + 3) por_n = 1;
    // R1 reset state
    chk("R1 tdo_oe after reset", tdo_oe, 0);
    chk("R1 stat_oe after reset", stat_oe, 0);
    chk("R1 err_oe after reset", err_oe, 0);
    to_reset();

    // R3 capture value
    scan_ir(8'h20, c8);
    chk("R3 ir capture", c8, 8'h01);
    chk("R1 tdo_oe off before enable", tdo_oe, 0);
    s0 = n_start;
    dr(24, {16'h1234, 8'h56});
    chk("R8 no request before enable", n_start, s0);

    // R2 reset state selects bypass
    to_reset();
    scan_dr(8, 24'hB5, c24);
    chk("R2 bypass after reset", c24[7:0], 8'h6A);
    ir(8'h5A);
    scan_dr(8, 24'h3C, c24);
    chk("R2 unknown opcode bypass", c24[7:0], 8'h78);

    // R1 R4 enable
    ir(8'h10);
    chk("R1 tdo_oe after enable", tdo_oe, 1);
    chk("R4 side pins off before option", stat_oe, 0);
    dr(3, 24'h1);
    chk("R5 stat idle", {stat_oe, stat_o}, 2'b11);
    fl_busy = 1; #1;
    chk("R5 stat busy", {stat_oe, stat_o}, 2'b10);
    fl_busy = 0; #1;
    chk("R6 err idle", {err_oe, err_o}, 2'b11);

    // R8 program sweep
    ir(8'h20);
    for (int i = 0; i < 8; i++) begin
      a = 16'(i * 16'h2345 + 16'h0111);
      d = 8'(i * 37 + 5);
      s0 = n_start;
      dr(24, {a, d});
      chk("R8 program issued", n_start, s0 + 1);
      chk("R8 program fields", {l_cmd, l_addr, l_data}, {2'd0, a, d});
    end

    // R13 read capture
    ir(8'h23);
    for (int i = 0; i < 4; i++) begin
      a = 16'(16'h4000 + i * 16'h1111);
      dr(24, {a, 8'h00});
      chk("R8 read cmd", {l_cmd, l_addr}, {2'd3, a});
      scan_dr(24, 24'h0, c24);
      chk("R13 read capture", c24, {a, rd(a)});
    end

    // R9 busy drops request
    fl_busy = 1;
    ir(8'h20);
    s0 = n_start;
    dr(24, {16'h0AAA, 8'h11});
    fl_busy = 0;
    idle(3);
    chk("R9 dropped while busy", n_start, s0);

    // R6 sticky error
    dr(24, {16'h0BBB, 8'h22});
    fl_err = 1; idle(1); fl_err = 0; idle(1);
    chk("R6 err set", {err_oe, err_o}, 2'b10);
    dr(24, {16'h0CCC, 8'h33});
    chk("R6 err sticky", {err_oe, err_o}, 2'b10);
    ir(8'h12);
    chk("R6 err cleared", {err_oe, err_o}, 2'b11);

    // R10 protect sweep
    for (int s = 0; s < 16; s++) begin
      ir(8'h21);
      a = 16'((s << 12) | 16'h0123);
      s0 = n_start;
      dr(24, {a, 8'h00});
      if (prot_mask[s]) begin
        chk("R10 protected not issued", n_start, s0);
        chk("R10 protected sets err", err_o, 0);
      end else begin
        chk("R10 erase issued", {n_start, l_cmd, l_addr}, {s0 + 1, 2'd1, a});
        chk("R10 no err", err_o, 1);
      end
      ir(8'h12);
    end

    // R4 R5 R6 option sweep
    for (int opt = 0; opt < 8; opt++) begin
      ir(8'h10);
      dr(3, 24'(opt));
      for (int e = 0; e < 2; e++) begin
        if (e == 1) begin ir(8'h21); dr(24, 24'h0); end
        for (int b = 0; b < 2; b++) begin
          logic en, so, eo, sl, el;
          en = opt[0]; so = opt[1]; eo = opt[2];
          sl = (b == 0); el = (e == 0);
          fl_busy = b[0]; #1;
          chk("R5 stat pin", {stat_oe, stat_o}, {en & (so ? ~sl : 1'b1), en & ~so & sl});
          chk("R4 err pin", {err_oe, err_o}, {en & (eo ? ~el : 1'b1), en & ~eo & el});
        end
        fl_busy = 0;
      end
      ir(8'h12);
    end

    // R7 conditional chip reset clear
    ir(8'h10); dr(3, 24'h1);
    ir(8'h21); dr(24, 24'h0);
    chip_reset_pulse();
    chk("R7 reset ignored while enabled", err_o, 0);
    ir(8'h11);
    chk("R1 disable releases pins", {tdo_oe, err_oe, stat_oe}, 3'b000);
    ir(8'h10); dr(3, 24'h1);
    chk("R7 disable alone keeps err", err_o, 0);
    ir(8'h11);
    chip_reset_pulse();
    ir(8'h10); dr(3, 24'h1);
    chk("R7 reset after disable clears", err_o, 1);

    // R11 R12 lock
    por_n = 0; sec_init = 1; #(TCK_PERIOD); por_n = 1;
    to_reset();
    ir(8'h10); dr(3, 24'h1);
    s0 = n_start;
    ir(8'h20); dr(24, {16'h0100, 8'h99});
    ir(8'h21); dr(24, {16'h2000, 8'h00});
    ir(8'h23); dr(24, {16'h3000, 8'h00});
    scan_dr(24, 24'h0, c24);
    chk("R11 locked ops ignored", n_start, s0);
    chk("R11 locked no err", err_o, 1);
    chk("R11 locked read zero", c24, 24'h0);
    ir(8'h22);
    dr(24, 24'h0);
    chk("R11 chip erase accepted", {n_start, l_cmd}, {s0 + 1, 2'd2});
    fl_busy = 1; idle(3);
    fl_busy = 0; fl_err = 1; idle(1); fl_err = 0; idle(1);
    ir(8'h23);
    scan_dr(24, 24'h0, c24);
    chk("R12 failed erase keeps lock", c24, 24'h0);
    ir(8'h12);
    ir(8'h22);
    dr(24, 24'h0);
    fl_busy = 1; idle(3);
    fl_busy = 0; idle(2);
    ir(8'h23);
    s0 = n_start;
    dr(24, {16'h1234, 8'h00});
    chk("R12 read issued after unlock", {n_start, l_addr}, {s0 + 1, 16'h1234});
    scan_dr(24, 24'h0, c24);
    chk("R12 data visible after unlock", c24, {16'h1234, rd(16'h1234)});

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(TCK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule